// File: doc/BRIEF.md
# Sprite per-line overflow status

This block watches sprite evaluation line by line and keeps two sticky overflow flags, which it presents together with a master/slave indication and a fixed version number as one status byte. Evaluation logic elsewhere pulses `sprite_hit_i` once for each sprite that falls on the current line, and `tile_hit_i` once for each sprite tile fetched for that line. A 16x16 sprite therefore delivers two tile strobes. `line_start_i` marks the start of every line.

The range flag records that some line in the current frame held more sprites than `RANGE_LIMIT`. The time flag records that some line held more tiles than `TIME_LIMIT`. The flags are set no matter whether sprite display is enabled. They survive forced blank and are cleared only by the end-of-vertical-blank pulse. The status byte is read combinationally, and reading it has no side effect.

Top module: `ovf_status`

## Requirements
- R1: While `rst_ni` is low, both flags are 0, so the status byte reads `{0,0,master_i,0,VERSION}`.
- R2: Status byte layout: bit 7 is the time flag, bit 6 is the range flag, bit 5 follows `master_i` in the same cycle, bit 4 reads 0, and bits 3:0 hold `VERSION` (1 by default).
- R3: The range flag sets at the clock edge that samples the sprite strobe taking the line's sprite count above `RANGE_LIMIT`. It is visible one cycle after that strobe is driven.
- R4: The time flag sets in the same way, at the strobe that takes the line's tile count above `TIME_LIMIT`. Each `tile_hit_i` strobe counts exactly one tile.
- R5: `line_start_i` restarts both per-line counts. A strobe that arrives in the same cycle as `line_start_i` counts as the first of the new line.
- R6: Once set, a flag stays set across later lines, with or without strobes, and across any level of `force_blank_i`, until `vblank_end_i` arrives.
- R7: `vblank_end_i` clears both flags one cycle later. If a strobe beyond a limit arrives in the same cycle, that flag is set instead of cleared.
- R8: Per-line counts saturate just above their limit and never wrap. After a clear in the middle of an overflowed line, each further strobe on that line sets its flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | Start-of-line pulse |
| sprite_hit_i | input | 1 | One sprite found on the current line |
| tile_hit_i | input | 1 | One sprite tile fetched for the current line |
| vblank_end_i | input | 1 | End-of-vertical-blank pulse |
| force_blank_i | input | 1 | Forced-blank level; has no effect on the flags |
| master_i | input | 1 | Master/slave indication, shown in bit 5 |
| status_o | output | 8 | Status byte |

## Verification
The bench builds the block with `RANGE_LIMIT` = 5 and `TIME_LIMIT` = 7. With these limits every pairing of 0 to 9 sprites with 0 to 11 tiles on a line can be swept, so each threshold is covered from both sides. The small counters (3 and 4 bits) let a 20-strobe line expose any wrap-around. The same configuration covers a line restart that coincides with a strobe, and a frame clear that coincides with an excess strobe.

// File: rtl/ovf_pkg.sv
package ovf_pkg;
  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned CH_RANGE = 0;
  localparam int unsigned CH_TIME  = 1;

  typedef struct packed {
    logic       time_ovf;
    logic       range_ovf;
    logic       master;
    logic       spare;
    logic [3:0] version;
  } ovf_status_t;
endpackage

// File: rtl/ovf_line_cnt.sv
module ovf_line_cnt #(
  parameter int unsigned LIMIT = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic hit_i,
  output logic excess_o
);
  localparam int unsigned W = $clog2(LIMIT + 2);
  localparam logic [W-1:0] SAT = W'(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (restart_i)              cnt_q <= hit_i ? W'(1) : '0;
    else if (hit_i && cnt_q != SAT)  cnt_q <= cnt_q + W'(1);
  end

  // strobe beyond the limit on the current line
  assign excess_o = hit_i && !restart_i && (cnt_q >= LIM);
endmodule

// File: rtl/ovf_sticky.sv
module ovf_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;  // set wins over clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ovf_status.sv
module ovf_status #(
  parameter int unsigned RANGE_LIMIT = 32,
  parameter int unsigned TIME_LIMIT  = 34,
  parameter int unsigned VERSION     = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_start_i,
  input  logic       sprite_hit_i,
  input  logic       tile_hit_i,
  input  logic       vblank_end_i,
  input  logic       force_blank_i,
  input  logic       master_i,
  output logic [7:0] status_o
);
  import ovf_pkg::*;

  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] excess;
  logic [NUM_CH-1:0] flag;
  ovf_status_t       stat;

  // forced blank never touches the flags
  logic unused_force_blank;
  assign unused_force_blank = force_blank_i;

  assign hit[CH_RANGE] = sprite_hit_i;
  assign hit[CH_TIME]  = tile_hit_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int unsigned LIM = (g == CH_RANGE) ? RANGE_LIMIT : TIME_LIMIT;

    ovf_line_cnt #(.LIMIT(LIM)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .restart_i(line_start_i),
      .hit_i    (hit[g]),
      .excess_o (excess[g])
    );

    ovf_sticky u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (excess[g]),
      .clr_i (vblank_end_i),
      .flag_o(flag[g])
    );
  end

  always_comb begin
    stat.time_ovf  = flag[CH_TIME];
    stat.range_ovf = flag[CH_RANGE];
    stat.master    = master_i;
    stat.spare     = 1'b0;
    stat.version   = 4'(VERSION);
  end

  assign status_o = stat;
endmodule

// File: rtl/ovf_status_chk.sv
module ovf_status_chk #(
  parameter int unsigned VERSION = 1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sprite_hit_i,
  input logic       tile_hit_i,
  input logic       vblank_end_i,
  input logic       master_i,
  input logic [7:0] status_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> status_o[7:6] == 2'b00);

  // R2
  fixed_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[4:0] == {1'b0, 4'(VERSION)});

  // R2
  master_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[5] == master_i);

  // R3
  range_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[6]) |-> $past(sprite_hit_i));

  // R4
  time_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[7]) |-> $past(tile_hit_i));

  // R6
  range_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6] && !vblank_end_i |=> status_o[6]);

  // R6
  time_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7] && !vblank_end_i |=> status_o[7]);

  // R7
  range_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_end_i && !sprite_hit_i |=> !status_o[6]);

  // R7
  time_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_end_i && !tile_hit_i |=> !status_o[7]);
endmodule

bind ovf_status ovf_status_chk #(.VERSION(VERSION)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sprite_hit_i(sprite_hit_i),
  .tile_hit_i  (tile_hit_i),
  .vblank_end_i(vblank_end_i),
  .master_i    (master_i),
  .status_o    (status_o)
);

// File: tb/sim_ovf_status.sv
module sim_ovf_status;
  localparam int RL = 5;
  localparam int TL = 7;

  logic clk = 1'b0;
  logic rst_ni;
  logic line_start, sprite_hit, tile_hit, vblank_end, force_blank, master;
  logic [7:0] status;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ovf_status #(.RANGE_LIMIT(RL), .TIME_LIMIT(TL), .VERSION(1)) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .line_start_i (line_start),
    .sprite_hit_i (sprite_hit),
    .tile_hit_i   (tile_hit),
    .vblank_end_i (vblank_end),
    .force_blank_i(force_blank),
    .master_i     (master),
    .status_o     (status)
  );

  function automatic logic [7:0] expect_st(input logic t, input logic r);
    return {t, r, master, 1'b0, 4'd1};
  endfunction

  task automatic drive(input logic ls, input logic sp, input logic tl, input logic vb);
    @(negedge clk);
    line_start = ls; sprite_hit = sp; tile_hit = tl; vblank_end = vb;
  endtask

  task automatic check(input string tag, input logic [7:0] exp);
    checks++;
    if (status !== exp) begin
      errors++;
      $display("FAIL %s: status=%h expected=%h", tag, status, exp);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; line_start = 0; sprite_hit = 0; tile_hit = 0;
    vblank_end = 0; force_blank = 0; master = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset", expect_st(0, 0));
    rst_ni = 1'b1;
    drive(0, 0, 0, 0);
    check("R2 layout after reset", expect_st(0, 0));

    // R3 R4 R6 R7 sweep of sprite and tile counts per line
    for (int ns = 0; ns < 10; ns++) begin
      for (int nt = 0; nt < 12; nt++) begin
        int mx;
        mx = (ns > nt) ? ns : nt;
        master = 1'((ns + nt) % 2);
        force_blank = 1'b0;
        drive(0, 0, 0, 1);
        drive(0, 0, 0, 0);
        check("R7 frame clear", expect_st(0, 0));
        drive(1, 0, 0, 0);
        for (int i = 0; i < mx; i++) begin
          force_blank = 1'((i % 3) == 0);
          drive(0, 1'(i < ns), 1'(i < nt), 0);
        end
        drive(0, 0, 0, 0);
        check("R3 R4 line result", expect_st(1'(nt > TL), 1'(ns > RL)));
        force_blank = 1'b1;
        drive(1, 0, 0, 0);
        drive(0, 0, 0, 0);
        check("R6 sticky over blank line", expect_st(1'(nt > TL), 1'(ns > RL)));
        force_blank = 1'b0;
      end
    end

    // R5 restart coinciding with a strobe
    master = 1'b0;
    drive(0, 0, 0, 1);
    drive(1, 0, 0, 0);
    for (int i = 0; i < RL; i++) drive(0, 1, 0, 0);
    drive(1, 1, 0, 0);
    for (int i = 0; i < RL - 1; i++) drive(0, 1, 0, 0);
    drive(0, 0, 0, 0);
    check("R5 restart counts strobe as first", expect_st(0, 0));
    drive(0, 1, 0, 0);
    drive(0, 0, 0, 0);
    check("R5 next strobe exceeds limit", expect_st(0, 1));

    // R8 saturation without wrap
    drive(0, 0, 0, 1);
    drive(1, 0, 0, 0);
    for (int i = 0; i < 20; i++) drive(0, 1, 1, 0);
    drive(0, 0, 0, 0);
    check("R8 long line overflows", expect_st(1, 1));
    drive(0, 0, 0, 1);
    drive(0, 0, 0, 0);
    check("R7 clear mid-line", expect_st(0, 0));
    drive(0, 1, 1, 0);
    drive(0, 0, 0, 0);
    check("R8 saturated count sets again", expect_st(1, 1));

    // R7 set wins over clear in the same cycle
    drive(0, 1, 0, 1);
    drive(0, 0, 0, 0);
    check("R7 set beats clear", expect_st(0, 1));

    finish_run();
  end
endmodule